// File: doc/BRIEF.md
# Synchronous Rectifying Demodulator Accumulator

This block demodulates two ADC sample streams, an in-phase (I) channel and a quadrature (Q) channel, against a square rectify reference. The reference is picked from four quadrature phases of the excitation square wave or from an external input, which may be inverted. A sample taken while the reference is high adds to the channel accumulator. A sample taken while it is low subtracts from it. Each accumulation window opens on a rising edge of the reference and spans a programmable number of reference periods.

When a window closes, the accumulated values are shifted right without regard to sign and published together with a timestamp. The timestamp can mark the start, the centre or the end of the window. The same edge also publishes per-window statistics: the sample counts in each reference half, and per channel, the counts of samples whose sign disagrees with the reference. The published values are compared against a high and a low amplitude limit. The outcomes land in sticky status bits that drive a masked, globally gated interrupt line. Windows that lack samples in either reference half can be discarded instead of published.

Top module: `rect_demod_acc`

## Requirements
- R1: `ref_sel` picks the rectify reference: codes 0, 1, 2 and 3 select `exc_ph[0]`, `exc_ph[1]`, `exc_ph[2]` and `exc_ph[3]` (the 0, 90, 180 and 270 degree excitation phases), code 4 selects `ext_ref` and code 5 selects the inverse of `ext_ref`.
- R2: With `acc_en` high, a window opens on the first rising edge of the selected reference and closes on the rising edge that ends `win_len`+1 periods. Every valid sample adds +s while the reference is high and -s while it is low. A sample in a rising-edge cycle belongs to the window that opens there.
- R3: Results are published by a one-cycle `res_vld` pulse in the cycle after the closing edge. The result outputs hold between pulses, and consecutive windows follow back to back.
- R4: `win_len` (0..255) may change while running. A window always uses the length captured at its opening edge.
- R5: `stamp_sel` 0 publishes `ts_in` as sampled in the closing-edge cycle, 1 publishes `ts_in` of the opening-edge cycle, and 2 publishes the floor of their mean.
- R6: `pos_cnt` and `neg_cnt` give the number of valid samples taken while the reference was high and while it was low in the published window.
- R7: Per channel, the mismatch-positive count is the number of negative samples taken while the reference was high. The mismatch-negative count is the number of positive samples taken while it was low. Zero counts as neither.
- R8: `i_res` and `q_res` are the window's AW-bit accumulator bit patterns shifted right logically by `shift_amt`.
- R9: A published result greater than `amp_max` sets that channel's high flag, and one less than `amp_min` sets its low flag; both comparisons are unsigned.
- R10: `sts` bits are: 0 I valid, 1 Q valid, 2 I high, 3 Q high, 4 I low, 5 Q low. They are sticky and are cleared by writing ones on `sts_clr`, and a set in the same cycle wins.
- R11: `irq` is high one cycle after `irq_glb_en` is high and some bit of `sts & sts_en` is set; otherwise it is low.
- R12: With `drop_bad` high, a window with no samples in either reference half is not published and sets no status. With `drop_bad` low, the same window is published.
- R13: With `acc_en` low, the accumulators and counts are cleared and nothing is published. After `acc_en` rises again, the first window opens at the next rising reference edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Accumulation enable |
| ref_sel | input | 3 | Rectify reference select |
| exc_ph | input | 4 | Excitation square wave at four quadrature phases |
| ext_ref | input | 1 | External rectify reference |
| win_len | input | LENW | Window length in reference periods, minus one |
| stamp_sel | input | 2 | Timestamp point select |
| ts_in | input | TW | Free-running time base |
| smp_vld | input | 1 | Both sample inputs carry a new sample |
| i_smp | input | DW | I sample, two's complement |
| q_smp | input | DW | Q sample, two's complement |
| shift_amt | input | SHW | Logical right shift applied to results |
| drop_bad | input | 1 | Discard windows missing a reference half |
| amp_max | input | AW | High amplitude limit |
| amp_min | input | AW | Low amplitude limit |
| sts_en | input | 6 | Per-bit interrupt enable |
| irq_glb_en | input | 1 | Global interrupt enable |
| sts_clr | input | 6 | Write-one-to-clear strobes for status |
| res_vld | output | 1 | Result published pulse |
| i_res | output | AW | I result |
| q_res | output | AW | Q result |
| res_ts | output | TW | Result timestamp |
| pos_cnt | output | CW | Samples in reference-high half |
| neg_cnt | output | CW | Samples in reference-low half |
| i_mis_pos | output | CW | I negative samples during high half |
| i_mis_neg | output | CW | I positive samples during low half |
| q_mis_pos | output | CW | Q negative samples during high half |
| q_mis_neg | output | CW | Q positive samples during low half |
| sts | output | 6 | Sticky status bits |
| irq | output | 1 | Interrupt request |

## Verification
Two things coincide on every rising reference edge: the closing of one window and the first sample of the next. The bench keeps `smp_vld` high on every cycle and shapes the samples from the selected reference, so a misplaced boundary sample shifts both the accumulated value and the half counts away from their closed-form values. The windows are also compared by timestamp distance. A second collision, a status set meeting a clear strobe, is judged by clearing only while accumulation is stopped and then checking that the remaining bits stay put.

// File: rtl/rda_pkg.sv
package rda_pkg;
    typedef enum logic [1:0] {
        STAMP_END   = 2'd0,
        STAMP_START = 2'd1,
        STAMP_MID   = 2'd2
    } stamp_e;

    localparam int unsigned NSTS     = 6;
    localparam int unsigned ST_VLD_I = 0;
    localparam int unsigned ST_VLD_Q = 1;
    localparam int unsigned ST_HI_I  = 2;
    localparam int unsigned ST_HI_Q  = 3;
    localparam int unsigned ST_LO_I  = 4;
    localparam int unsigned ST_LO_Q  = 5;
endpackage

// File: rtl/rda_ref_sel.sv
module rda_ref_sel (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel_i,
    input  logic [3:0] exc_ph_i,
    input  logic       ext_i,
    output logic       ref_o,
    output logic       rise_o
);
    typedef struct packed {
        logic prev;
    } rs_t;

    rs_t s_d, s_q;
    logic ref_c;

    always_comb begin
        case (sel_i)
            3'd0, 3'd1, 3'd2, 3'd3: ref_c = exc_ph_i[sel_i[1:0]];
            3'd4:                   ref_c = ext_i;
            3'd5:                   ref_c = ~ext_i;
            default:                ref_c = 1'b0;
        endcase
        s_d      = s_q;
        s_d.prev = ref_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ref_o  = ref_c;
    assign rise_o = ref_c & ~s_q.prev;
endmodule

// File: rtl/rda_chan.sv
module rda_chan #(
    parameter int unsigned DW = 12,
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    input  logic          restart_i,
    input  logic          ref_i,
    input  logic          vld_i,
    input  logic [DW-1:0] smp_i,
    output logic [AW-1:0] acc_o,
    output logic [CW-1:0] mis_pos_o,
    output logic [CW-1:0] mis_neg_o
);
    localparam int unsigned EXT = AW - DW;

    typedef struct packed {
        logic [AW-1:0] acc;
        logic [CW-1:0] mp;
        logic [CW-1:0] mn;
    } ch_t;

    ch_t c_d, c_q;
    logic [AW-1:0] sx, contrib;
    logic          is_neg, is_pos, mp_inc, mn_inc;

    always_comb begin
        sx      = {{EXT{smp_i[DW-1]}}, smp_i};
        contrib = !vld_i ? '0 : (ref_i ? sx : ('0 - sx));
        is_neg  = smp_i[DW-1];
        is_pos  = !smp_i[DW-1] && (smp_i != '0);
        mp_inc  = vld_i & ref_i & is_neg;
        mn_inc  = vld_i & ~ref_i & is_pos;

        c_d = c_q;
        if (!run_i) begin
            c_d = '0;
        end else if (restart_i) begin
            c_d.acc = contrib;
            c_d.mp  = {{(CW-1){1'b0}}, mp_inc};
            c_d.mn  = {{(CW-1){1'b0}}, mn_inc};
        end else begin
            c_d.acc = c_q.acc + contrib;
            if (mp_inc && (c_q.mp != '1)) c_d.mp = c_q.mp + 1'b1;
            if (mn_inc && (c_q.mn != '1)) c_d.mn = c_q.mn + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign acc_o     = c_q.acc;
    assign mis_pos_o = c_q.mp;
    assign mis_neg_o = c_q.mn;

    AST_MIS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !restart_i) |=> ((mis_pos_o == $past(mis_pos_o)) || (mis_pos_o == $past(mis_pos_o) + 1'b1))); // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (acc_o == '0 && mis_neg_o == '0)); // R13
endmodule

// File: rtl/rda_status.sv
module rda_status #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] en_i,
    input  logic         glb_i,
    output logic [N-1:0] sts_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [N-1:0] sts;
        logic         irq;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sts = (s_q.sts & ~clr_i) | set_i;
        s_d.irq = glb_i & (|(s_q.sts & en_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sts_o = s_q.sts;
    assign irq_o = s_q.irq;

    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_o & $past(sts_o & ~clr_i)) == $past(sts_o & ~clr_i))); // R10
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_i |=> !irq_o); // R11
endmodule

// File: rtl/rect_demod_acc.sv
module rect_demod_acc #(
    parameter int unsigned DW   = 12,
    parameter int unsigned AW   = 32,
    parameter int unsigned TW   = 32,
    parameter int unsigned LENW = 8,
    parameter int unsigned CW   = 16,
    parameter int unsigned SHW  = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acc_en,
    input  logic [2:0]      ref_sel,
    input  logic [3:0]      exc_ph,
    input  logic            ext_ref,
    input  logic [LENW-1:0] win_len,
    input  logic [1:0]      stamp_sel,
    input  logic [TW-1:0]   ts_in,
    input  logic            smp_vld,
    input  logic [DW-1:0]   i_smp,
    input  logic [DW-1:0]   q_smp,
    input  logic [SHW-1:0]  shift_amt,
    input  logic            drop_bad,
    input  logic [AW-1:0]   amp_max,
    input  logic [AW-1:0]   amp_min,
    input  logic [5:0]      sts_en,
    input  logic            irq_glb_en,
    input  logic [5:0]      sts_clr,
    output logic            res_vld,
    output logic [AW-1:0]   i_res,
    output logic [AW-1:0]   q_res,
    output logic [TW-1:0]   res_ts,
    output logic [CW-1:0]   pos_cnt,
    output logic [CW-1:0]   neg_cnt,
    output logic [CW-1:0]   i_mis_pos,
    output logic [CW-1:0]   i_mis_neg,
    output logic [CW-1:0]   q_mis_pos,
    output logic [CW-1:0]   q_mis_neg,
    output logic [5:0]      sts,
    output logic            irq
);
    import rda_pkg::*;

    localparam int unsigned NCH = 2;

    typedef struct packed {
        logic            running;
        logic [LENW-1:0] per_cnt;
        logic [LENW-1:0] len_cur;
        logic [TW-1:0]   start_ts;
        logic [CW-1:0]   pcnt;
        logic [CW-1:0]   ncnt;
        logic            vld;
        logic [AW-1:0]   ires;
        logic [AW-1:0]   qres;
        logic [TW-1:0]   ts;
        logic [CW-1:0]   pout;
        logic [CW-1:0]   nout;
        logic [CW-1:0]   imp;
        logic [CW-1:0]   imn;
        logic [CW-1:0]   qmp;
        logic [CW-1:0]   qmn;
    } win_t;

    win_t w_d, w_q;

    logic ref_c, rise_c;
    logic rise_en, start_w, close_w, restart_w, run_w, bad_w, publish_w;
    logic [AW-1:0] acc_a [NCH];
    logic [CW-1:0] mp_a  [NCH];
    logic [CW-1:0] mn_a  [NCH];
    logic [DW-1:0] smp_a [NCH];
    logic [AW-1:0] sh_a  [NCH];
    logic [TW:0]   ts_sum;
    logic [NSTS-1:0] set_w;

    rda_ref_sel u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_i    (ref_sel),
        .exc_ph_i (exc_ph),
        .ext_i    (ext_ref),
        .ref_o    (ref_c),
        .rise_o   (rise_c)
    );

    assign smp_a[0] = i_smp;
    assign smp_a[1] = q_smp;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rda_chan #(.DW(DW), .AW(AW), .CW(CW)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_i     (run_w),
            .restart_i (restart_w),
            .ref_i     (ref_c),
            .vld_i     (smp_vld),
            .smp_i     (smp_a[c]),
            .acc_o     (acc_a[c]),
            .mis_pos_o (mp_a[c]),
            .mis_neg_o (mn_a[c])
        );
        assign sh_a[c] = acc_a[c] >> shift_amt;
    end

    always_comb begin
        rise_en   = acc_en & rise_c;
        start_w   = rise_en & ~w_q.running;
        close_w   = rise_en & w_q.running & (w_q.per_cnt == w_q.len_cur);
        restart_w = start_w | close_w;
        run_w     = acc_en & (w_q.running | rise_c);
        bad_w     = (w_q.pcnt == '0) || (w_q.ncnt == '0);
        publish_w = close_w & ~(drop_bad & bad_w);
        ts_sum    = {1'b0, w_q.start_ts} + {1'b0, ts_in};

        w_d     = w_q;
        w_d.vld = 1'b0;

        if (!acc_en) begin
            w_d.running = 1'b0;
            w_d.per_cnt = '0;
            w_d.pcnt    = '0;
            w_d.ncnt    = '0;
        end else if (restart_w) begin
            w_d.running  = 1'b1;
            w_d.per_cnt  = '0;
            w_d.len_cur  = win_len;
            w_d.start_ts = ts_in;
            w_d.pcnt     = {{(CW-1){1'b0}}, smp_vld & ref_c};
            w_d.ncnt     = {{(CW-1){1'b0}}, smp_vld & ~ref_c};
        end else if (w_q.running) begin
            if (rise_c) w_d.per_cnt = w_q.per_cnt + 1'b1;
            if (smp_vld && ref_c && (w_q.pcnt != '1))  w_d.pcnt = w_q.pcnt + 1'b1;
            if (smp_vld && !ref_c && (w_q.ncnt != '1)) w_d.ncnt = w_q.ncnt + 1'b1;
        end

        set_w = '0;
        if (publish_w) begin
            w_d.vld  = 1'b1;
            w_d.ires = sh_a[0];
            w_d.qres = sh_a[1];
            case (stamp_e'(stamp_sel))
                STAMP_START: w_d.ts = w_q.start_ts;
                STAMP_MID:   w_d.ts = ts_sum[TW:1];
                default:     w_d.ts = ts_in;
            endcase
            w_d.pout = w_q.pcnt;
            w_d.nout = w_q.ncnt;
            w_d.imp  = mp_a[0];
            w_d.imn  = mn_a[0];
            w_d.qmp  = mp_a[1];
            w_d.qmn  = mn_a[1];
            set_w[ST_VLD_I] = 1'b1;
            set_w[ST_VLD_Q] = 1'b1;
            set_w[ST_HI_I]  = sh_a[0] > amp_max;
            set_w[ST_HI_Q]  = sh_a[1] > amp_max;
            set_w[ST_LO_I]  = sh_a[0] < amp_min;
            set_w[ST_LO_Q]  = sh_a[1] < amp_min;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    rda_status #(.N(NSTS)) u_sts (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_w),
        .clr_i (sts_clr),
        .en_i  (sts_en),
        .glb_i (irq_glb_en),
        .sts_o (sts),
        .irq_o (irq)
    );

    assign res_vld   = w_q.vld;
    assign i_res     = w_q.ires;
    assign q_res     = w_q.qres;
    assign res_ts    = w_q.ts;
    assign pos_cnt   = w_q.pout;
    assign neg_cnt   = w_q.nout;
    assign i_mis_pos = w_q.imp;
    assign i_mis_neg = w_q.imn;
    assign q_mis_pos = w_q.qmp;
    assign q_mis_neg = w_q.qmn;

    AST_VLD_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> !res_vld); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_en |=> !res_vld); // R13
    AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && $past(drop_bad)) |-> (pos_cnt != '0 && neg_cnt != '0)); // R12
    AST_MIS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (i_mis_pos <= pos_cnt && q_mis_pos <= pos_cnt &&
                     i_mis_neg <= neg_cnt && q_mis_neg <= neg_cnt)); // R7
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |=> (res_vld || $stable(i_res))); // R3
endmodule

// File: tb/rect_demod_acc_tb_top.sv
`timescale 1ns/1ps
module rect_demod_acc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic [2:0]  ref_sel = 3'd0;
    logic [3:0]  exc_ph = 4'd0;
    logic        ext_ref = 1'b0;
    logic [7:0]  win_len = 8'd0;
    logic [1:0]  stamp_sel = 2'd0;
    logic        smp_vld = 1'b0;
    logic [11:0] i_smp = '0;
    logic [11:0] q_smp = '0;
    logic [4:0]  shift_amt = '0;
    logic        drop_bad = 1'b0;
    logic [31:0] amp_max = '1;
    logic [31:0] amp_min = '0;
    logic [5:0]  sts_en = '0;
    logic        irq_glb_en = 1'b0;
    logic [5:0]  sts_clr = '0;
    logic        res_vld;
    logic [31:0] i_res, q_res, res_ts;
    logic [15:0] pos_cnt, neg_cnt, i_mis_pos, i_mis_neg, q_mis_pos, q_mis_neg;
    logic [5:0]  sts;
    logic        irq;

    int  tsc = 0;
    int  ph = 0;
    bit  hionly = 0;
    int  n_chk = 0;
    int  n_err = 0;
    bit  done = 0;

    always #2.5 clk = ~clk;

    rect_demod_acc dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .ref_sel(ref_sel),
        .exc_ph(exc_ph), .ext_ref(ext_ref), .win_len(win_len),
        .stamp_sel(stamp_sel), .ts_in(tsc), .smp_vld(smp_vld),
        .i_smp(i_smp), .q_smp(q_smp), .shift_amt(shift_amt),
        .drop_bad(drop_bad), .amp_max(amp_max), .amp_min(amp_min),
        .sts_en(sts_en), .irq_glb_en(irq_glb_en), .sts_clr(sts_clr),
        .res_vld(res_vld), .i_res(i_res), .q_res(q_res), .res_ts(res_ts),
        .pos_cnt(pos_cnt), .neg_cnt(neg_cnt), .i_mis_pos(i_mis_pos),
        .i_mis_neg(i_mis_neg), .q_mis_pos(q_mis_pos), .q_mis_neg(q_mis_neg),
        .sts(sts), .irq(irq)
    );

    function automatic bit hi_at(int k, int p);
        return (((p - 2 * k) % 8 + 8) % 8) < 4;
    endfunction

    function automatic bit ext_at(int p);
        return (((p - 1) % 8 + 8) % 8) < 4;
    endfunction

    function automatic bit ref_at(logic [2:0] s, int p);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: return hi_at(int'(s), p);
            3'd4:    return ext_at(p);
            3'd5:    return !ext_at(p);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] u32(int v);
        return 32'(v);
    endfunction

    // stimulus: period-8 references; samples shaped by the selected reference
    initial begin
        forever begin
            @(posedge clk);
            begin
                int  np;
                bit  r;
                np = (ph + 1) % 8;
                r  = ref_at(ref_sel, np);
                ph      <= np;
                tsc     <= tsc + 1;
                exc_ph  <= {hi_at(3, np), hi_at(2, np), hi_at(1, np), hi_at(0, np)};
                ext_ref <= ext_at(np);
                smp_vld <= hionly ? r : 1'b1;
                i_smp   <= r ? 12'h003 : 12'hFFE;
                q_smp   <= r ? 12'hFFF : 12'h005;
            end
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_res(string req, output int t);
        bit ok;
        ok = 0;
        t  = 0;
        for (int k = 0; k < 400 && !ok; k++) begin
            @(negedge clk);
            if (res_vld) begin
                ok = 1;
                t  = tsc;
            end
        end
        if (!ok) chk(req, "result timeout", 0, 1);
    endtask

    task automatic check_full(string req, int m);
        chk({req, " R2"}, "i_res", i_res, u32(20 * m));
        chk({req, " R2"}, "q_res", q_res, u32(-24 * m));
        chk({req, " R6"}, "pos_cnt", pos_cnt, 4 * m);
        chk({req, " R6"}, "neg_cnt", neg_cnt, 4 * m);
        chk({req, " R7"}, "i_mis_pos", i_mis_pos, 0);
        chk({req, " R7"}, "i_mis_neg", i_mis_neg, 0);
        chk({req, " R7"}, "q_mis_pos", q_mis_pos, 4 * m);
        chk({req, " R7"}, "q_mis_neg", q_mis_neg, 4 * m);
    endtask

    task automatic restart_cfg(logic [2:0] s, logic [7:0] l, logic [1:0] st, logic [4:0] sh);
        @(negedge clk);
        acc_en    = 1'b0;
        ref_sel   = s;
        win_len   = l;
        stamp_sel = st;
        shift_amt = sh;
        repeat (3) @(negedge clk);
        acc_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 reset", "res_vld", res_vld, 0);
        chk("R10 reset", "sts", sts, 0);
        chk("R11 reset", "irq", irq, 0);
        chk("R8 reset", "i_res", i_res, 0);

        // R1: sweep every reference code, one-period windows, end stamp
        for (int s = 0; s < 6; s++) begin
            restart_cfg(3'(s), 8'd0, 2'd0, 5'd0);
            wait_res("R1", t0);
            check_full("R1", 1);
            chk("R5 end", "res_ts", res_ts, u32(t0 - 1));
            wait_res("R3", t1);
            check_full("R1", 1);
            chk("R3 back-to-back", "spacing", u32(t1 - t0), 8);
            @(negedge clk);
            chk("R3 pulse", "res_vld", res_vld, 0);
        end

        // R5 start stamp, three-period window, then centre stamp
        restart_cfg(3'd2, 8'd2, 2'd1, 5'd0);
        wait_res("R5", t0);
        check_full("R5 start", 3);
        chk("R5 start", "res_ts", res_ts, u32(t0 - 1 - 24));
        stamp_sel = 2'd2;
        wait_res("R5", t0);
        chk("R5 centre", "res_ts", res_ts, u32(t0 - 1 - 12));
        // R4: shorten while running; the open window keeps its length
        win_len = 8'd0;
        stamp_sel = 2'd0;
        wait_res("R4", t1);
        chk("R4 old length", "spacing", u32(t1 - t0), 24);
        check_full("R4 old length", 3);
        wait_res("R4", t0);
        chk("R4 new length", "spacing", u32(t0 - t1), 8);
        check_full("R4 new length", 1);

        // R8: logical shift of the window pattern
        restart_cfg(3'd0, 8'd1, 2'd0, 5'd3);
        wait_res("R8", t0);
        chk("R8", "i_res", i_res, u32(40) >> 3);
        chk("R8", "q_res", q_res, u32(-48) >> 3);

        // R9/R10: limits into status
        @(negedge clk);
        acc_en  = 1'b0;
        amp_max = 32'd100;
        amp_min = 32'd50;
        sts_clr = 6'h3F;
        @(negedge clk);
        sts_clr = 6'h00;
        chk("R10 clear", "sts", sts, 0);
        restart_cfg(3'd0, 8'd0, 2'd0, 5'd0);
        wait_res("R9", t0);
        chk("R9 limits", "sts", sts, 6'h1B);

        // R11: interrupt gating
        sts_en = 6'h01;
        repeat (3) @(negedge clk);
        chk("R11 gated off", "irq", irq, 0);
        irq_glb_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 gated on", "irq", irq, 1);
        acc_en = 1'b0;
        @(negedge clk);
        sts_clr = 6'h01;
        @(negedge clk);
        sts_clr = 6'h00;
        chk("R10 partial clear", "sts", sts, 6'h1A);
        repeat (2) @(negedge clk);
        chk("R11 after clear", "irq", irq, 0);
        repeat (10) @(negedge clk);
        chk("R10 sticky", "sts", sts, 6'h1A);
        irq_glb_en = 1'b0;
        amp_max = '1;
        amp_min = '0;

        // R12: windows with an empty low half
        hionly   = 1;
        drop_bad = 1'b1;
        restart_cfg(3'd0, 8'd0, 2'd0, 5'd0);
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (res_vld) seen++;
            end
            chk("R12 dropped", "results", seen, 0);
            chk("R12 no status", "sts", sts, 6'h1A);
        end
        drop_bad = 1'b0;
        wait_res("R12", t0);
        chk("R12 kept", "pos_cnt", pos_cnt, 4);
        chk("R12 kept", "neg_cnt", neg_cnt, 0);
        chk("R12 kept", "i_res", i_res, 12);
        chk("R12 kept", "q_res", q_res, u32(-4));
        chk("R12 kept", "q_mis_pos", q_mis_pos, 4);

        // R13: disabled accumulation publishes nothing, re-enable is clean
        @(negedge clk);
        acc_en = 1'b0;
        hionly = 0;
        begin
            int seen;
            seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (res_vld) seen++;
            end
            chk("R13 idle", "results", seen, 0);
            chk("R13 hold", "i_res", i_res, 12);
        end
        acc_en = 1'b1;
        wait_res("R13", t0);
        check_full("R13 re-enable", 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule